// File: doc/BRIEF.md
# Illegal access reset detector

This block sits beside a small processor core and watches three event streams: writes into the working registers, uses of a working register as an address pointer, and reloads of the program counter. It requests a reset when the core dereferences a register that has held no value since the last reset. It also requests one when a program counter reload lands inside a restricted address range.

The block keeps one "written" bit per working register. A reset clears all of them except the stack pointer's bit, which is always treated as set. Two protected segments, a boot segment and a secure segment, each have a programmable inclusive base/limit window and an enable bit. Any reload whose target falls in an enabled window is a security violation. A reload is tagged either as a branch-type flow change (call, jump, computed jump, return) or as a vector-type flow change (interrupt or trap vector), and the cause code reports which kind it was.

The reset request is a registered one-cycle pulse. It appears in the cycle after the offending event, and a 2-bit cause code is valid with it. Register-initialisation faults and security faults both drive the same request line.

Top module: `illegal_access_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rst_req` is 0 and `rst_cause` is 00.
- R2: A pointer use (`ptr_en`) of a register index 0..14 that has not been written since reset gives `rst_req`=1 with `rst_cause`=01 in the next cycle.
- R3: A pointer use of a register that was written in an earlier cycle since reset gives no request, and the written state persists across later cycles.
- R4: A pointer use of index 15 (stack pointer) never gives a request, even right after reset.
- R5: A write and a pointer use of the same index in the same cycle count as initialised (no request). A write to a different index in that cycle does not prevent the fault.
- R6: A branch-type reload (`pc_kind`=0) whose target lies in an enabled segment window, base and limit inclusive, gives `rst_req`=1 with `rst_cause`=10 in the next cycle.
- R7: A vector-type reload (`pc_kind`=1) into an enabled segment window gives `rst_req`=1 with `rst_cause`=11 in the next cycle.
- R8: A reload whose target is outside every enabled window (one below base, one above limit) or inside a disabled window gives no request.
- R9: `rst_req` lasts exactly one cycle per offending event, and `rst_cause` is 00 whenever `rst_req` is 0.
- R10: When a security violation and an uninitialised pointer use fall in the same cycle, one request is raised and the cause is the security code (10 or 11).
- R11: A second reset clears the written state again, so a register written before it faults on its next pointer use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Working register write strobe |
| wr_idx | input | IDX_W | Index of register being written |
| ptr_en | input | 1 | Register used as address pointer |
| ptr_idx | input | IDX_W | Index of register used as pointer |
| pc_load | input | 1 | Program counter reload event |
| pc_kind | input | 1 | 0 = branch-type reload, 1 = vector-type reload |
| pc_target | input | ADDR_W | Reload target address |
| boot_en | input | 1 | Boot segment protection enable |
| boot_base | input | ADDR_W | Boot segment lowest restricted address |
| boot_limit | input | ADDR_W | Boot segment highest restricted address |
| sec_en | input | 1 | Secure segment protection enable |
| sec_base | input | ADDR_W | Secure segment lowest restricted address |
| sec_limit | input | ADDR_W | Secure segment highest restricted address |
| rst_req | output | 1 | One-cycle reset request pulse |
| rst_cause | output | 2 | 00 none, 01 uninitialised pointer, 10 branch security, 11 vector security |

## Verification
Two situations can land in the same cycle. The first is a pointer use of a never-written register together with a reload into a protected window. The bench provokes it for both reload kinds and expects a single pulse that carries the security code. The second is a write and a pointer use in one cycle. The bench drives it once with matching indices, where no request is expected, and once with different indices, where the uninitialised-pointer code is expected.

// File: rtl/illegal_access_guard_pkg.sv
package illegal_access_guard_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'b00,
        CAUSE_WREG       = 2'b01,
        CAUSE_SEC_BRANCH = 2'b10,
        CAUSE_SEC_VECTOR = 2'b11
    } cause_e;

    localparam logic PC_KIND_BRANCH = 1'b0;
    localparam logic PC_KIND_VECTOR = 1'b1;

    typedef struct packed {
        logic   req;
        cause_e cause;
    } guard_out_t;

endpackage

// File: rtl/wreg_init_tracker.sv
module wreg_init_tracker #(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             ptr_en,
    input  logic [IDX_W-1:0] ptr_idx,
    output logic             ptr_fault
);
    // The top index is the stack pointer: always considered written.
    localparam logic [NUM_REGS-1:0] FLAGS_AT_RESET = {1'b1, {(NUM_REGS-1){1'b0}}};

    logic [NUM_REGS-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                flags_d[i] = 1'b1;
            end
        end
        flags_d[NUM_REGS-1] = 1'b1;
        // Same-cycle write bypass: a write wins over a pointer use.
        ptr_fault = ptr_en && !flags_d[ptr_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAGS_AT_RESET;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/segment_window.sv
module segment_window #(
    parameter int ADDR_W = 16
) (
    input  logic              win_en,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_limit,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb begin
        hit = win_en && (addr >= win_base) && (addr <= win_limit);
    end
endmodule

// File: rtl/illegal_access_guard.sv
module illegal_access_guard
    import illegal_access_guard_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              ptr_en,
    input  logic [IDX_W-1:0]  ptr_idx,
    input  logic              pc_load,
    input  logic              pc_kind,
    input  logic [ADDR_W-1:0] pc_target,
    input  logic              boot_en,
    input  logic [ADDR_W-1:0] boot_base,
    input  logic [ADDR_W-1:0] boot_limit,
    input  logic              sec_en,
    input  logic [ADDR_W-1:0] sec_base,
    input  logic [ADDR_W-1:0] sec_limit,
    output logic              rst_req,
    output logic [1:0]        rst_cause
);
    localparam int NUM_SEGS = 2;

    logic                          ptr_fault;
    logic [NUM_SEGS-1:0]           seg_en;
    logic [NUM_SEGS-1:0][ADDR_W-1:0] seg_base;
    logic [NUM_SEGS-1:0][ADDR_W-1:0] seg_limit;
    logic [NUM_SEGS-1:0]           seg_hit;
    logic                          sec_fault;

    guard_out_t st_d, st_q;

    wreg_init_tracker #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) tracker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .ptr_en    (ptr_en),
        .ptr_idx   (ptr_idx),
        .ptr_fault (ptr_fault)
    );

    assign seg_en    = {sec_en, boot_en};
    assign seg_base  = {sec_base, boot_base};
    assign seg_limit = {sec_limit, boot_limit};

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        segment_window #(
            .ADDR_W (ADDR_W)
        ) win_i (
            .win_en    (seg_en[g]),
            .win_base  (seg_base[g]),
            .win_limit (seg_limit[g]),
            .addr      (pc_target),
            .hit       (seg_hit[g])
        );
    end

    always_comb begin
        sec_fault = pc_load && (|seg_hit);
        st_d.req   = sec_fault || ptr_fault;
        st_d.cause = CAUSE_NONE;
        if (sec_fault) begin
            st_d.cause = (pc_kind == PC_KIND_VECTOR) ? CAUSE_SEC_VECTOR : CAUSE_SEC_BRANCH;
        end else if (ptr_fault) begin
            st_d.cause = CAUSE_WREG;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{req: 1'b0, cause: CAUSE_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req   = st_q.req;
    assign rst_cause = st_q.cause;

endmodule

// File: rtl/illegal_access_guard_chk.sv
module illegal_access_guard_chk #(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              ptr_en,
    input logic [IDX_W-1:0]  ptr_idx,
    input logic              pc_load,
    input logic              pc_kind,
    input logic [ADDR_W-1:0] pc_target,
    input logic              boot_en,
    input logic [ADDR_W-1:0] boot_base,
    input logic [ADDR_W-1:0] boot_limit,
    input logic              sec_en,
    input logic [ADDR_W-1:0] sec_base,
    input logic [ADDR_W-1:0] sec_limit,
    input logic              rst_req,
    input logic [1:0]        rst_cause
);
    logic in_boot, in_sec;
    assign in_boot = boot_en && (pc_target >= boot_base) && (pc_target <= boot_limit);
    assign in_sec  = sec_en && (pc_target >= sec_base) && (pc_target <= sec_limit);

    assert_stack_ptr_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && ptr_idx == IDX_W'(NUM_REGS-1) && !pc_load) |=> !rst_req);

    assert_same_cycle_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr_en && wr_idx == ptr_idx && !pc_load) |=> !rst_req);

    assert_branch_boot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !pc_kind && in_boot) |=> (rst_req && rst_cause == 2'b10));

    assert_vector_secure_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_kind && in_sec) |=> (rst_req && rst_cause == 2'b11));

    assert_no_event_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_en && !(pc_load && (in_boot || in_sec))) |=> !rst_req);

    assert_cause_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |-> (rst_cause == 2'b00));

    assert_cause_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rst_cause != 2'b00));

    assert_security_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && pc_load && (in_boot || in_sec)) |=> (rst_req && rst_cause[1]));

    // Write index is only meaningful together with the same-cycle check above.
    logic unused_ok;
    assign unused_ok = wr_en ^ (|wr_idx);

endmodule

bind illegal_access_guard illegal_access_guard_chk #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
) chk_i (.*);

// File: tb/illegal_access_guard_tb_top.sv
`timescale 1ns/1ps
module illegal_access_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        ptr_en = 1'b0;
    logic [3:0]  ptr_idx = '0;
    logic        pc_load = 1'b0;
    logic        pc_kind = 1'b0;
    logic [15:0] pc_target = '0;
    logic        boot_en = 1'b1;
    logic [15:0] boot_base = 16'h0100;
    logic [15:0] boot_limit = 16'h01FF;
    logic        sec_en = 1'b1;
    logic [15:0] sec_base = 16'h0800;
    logic [15:0] sec_limit = 16'h0FFF;
    logic        rst_req;
    logic [1:0]  rst_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    illegal_access_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx),
        .ptr_en(ptr_en), .ptr_idx(ptr_idx),
        .pc_load(pc_load), .pc_kind(pc_kind), .pc_target(pc_target),
        .boot_en(boot_en), .boot_base(boot_base), .boot_limit(boot_limit),
        .sec_en(sec_en), .sec_base(sec_base), .sec_limit(sec_limit),
        .rst_req(rst_req), .rst_cause(rst_cause)
    );

    task automatic check(input string tag, input logic exp_req, input logic [1:0] exp_cause);
        checks++;
        if (rst_req !== exp_req || rst_cause !== exp_cause) begin
            errors++;
            $display("FAIL %s: req=%0b cause=%0d expected req=%0b cause=%0d",
                     tag, rst_req, rst_cause, exp_req, exp_cause);
        end
    endtask

    // Drive one cycle of stimulus after a falling edge; on return the rising
    // edge has registered it and the outputs show its result.
    task automatic fire(input logic we, input logic [3:0] wi, input logic pe,
                        input logic [3:0] pi, input logic pl, input logic pk,
                        input logic [15:0] pt);
        wr_en = we; wr_idx = wi; ptr_en = pe; ptr_idx = pi;
        pc_load = pl; pc_kind = pk; pc_target = pt;
        @(negedge clk);
        wr_en = 1'b0; ptr_en = 1'b0; pc_load = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 during reset", 1'b0, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 2'b00);
    endtask

    task automatic t_uninit();
        fire(1'b0, 4'd0, 1'b1, 4'd3, 1'b0, 1'b0, 16'h0);
        check("R2 uninit reg3", 1'b1, 2'b01);
        @(negedge clk);
        check("R9 pulse ends", 1'b0, 2'b00);
    endtask

    task automatic t_written();
        fire(1'b1, 4'd3, 1'b0, 4'd0, 1'b0, 1'b0, 16'h0);
        check("R3 write only", 1'b0, 2'b00);
        fire(1'b0, 4'd0, 1'b1, 4'd3, 1'b0, 1'b0, 16'h0);
        check("R3 written reg3", 1'b0, 2'b00);
        fire(1'b1, 4'd5, 1'b0, 4'd0, 1'b0, 1'b0, 16'h0);
        repeat (3) @(negedge clk);
        fire(1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 1'b0, 16'h0);
        check("R3 persist reg5", 1'b0, 2'b00);
        fire(1'b0, 4'd0, 1'b1, 4'd3, 1'b0, 1'b0, 16'h0);
        check("R3 persist reg3", 1'b0, 2'b00);
    endtask

    task automatic t_stack_ptr();
        fire(1'b0, 4'd0, 1'b1, 4'd15, 1'b0, 1'b0, 16'h0);
        check("R4 stack pointer", 1'b0, 2'b00);
    endtask

    task automatic t_same_cycle();
        fire(1'b1, 4'd7, 1'b1, 4'd7, 1'b0, 1'b0, 16'h0);
        check("R5 same idx", 1'b0, 2'b00);
        fire(1'b1, 4'd8, 1'b1, 4'd9, 1'b0, 1'b0, 16'h0);
        check("R5 other idx", 1'b1, 2'b01);
        fire(1'b0, 4'd0, 1'b1, 4'd8, 1'b0, 1'b0, 16'h0);
        check("R5 reg8 now written", 1'b0, 2'b00);
    endtask

    task automatic t_branch();
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 16'h0100);
        check("R6 boot base", 1'b1, 2'b10);
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 16'h01FF);
        check("R6 boot limit", 1'b1, 2'b10);
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 16'h0A00);
        check("R6 branch secure", 1'b1, 2'b10);
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 16'h00FF);
        check("R8 below boot", 1'b0, 2'b00);
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 16'h0200);
        check("R8 above boot", 1'b0, 2'b00);
    endtask

    task automatic t_vector();
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 16'h0800);
        check("R7 secure base", 1'b1, 2'b11);
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 16'h0FFF);
        check("R7 secure limit", 1'b1, 2'b11);
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 16'h0150);
        check("R7 vector boot", 1'b1, 2'b11);
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 16'h1000);
        check("R8 above secure", 1'b0, 2'b00);
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 16'h07FF);
        check("R8 below secure", 1'b0, 2'b00);
    endtask

    task automatic t_disabled();
        boot_en = 1'b0;
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 16'h0150);
        check("R8 boot disabled", 1'b0, 2'b00);
        boot_en = 1'b1;
        sec_en = 1'b0;
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 16'h0900);
        check("R8 secure disabled", 1'b0, 2'b00);
        sec_en = 1'b1;
        fire(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 16'h0900);
        check("R8 no reload strobe", 1'b0, 2'b00);
    endtask

    task automatic t_collision();
        fire(1'b0, 4'd0, 1'b1, 4'd10, 1'b1, 1'b0, 16'h0900);
        check("R10 ptr+branch", 1'b1, 2'b10);
        fire(1'b0, 4'd0, 1'b1, 4'd10, 1'b1, 1'b1, 16'h0180);
        check("R10 ptr+vector", 1'b1, 2'b11);
        @(negedge clk);
        check("R9 idle after collision", 1'b0, 2'b00);
    endtask

    task automatic t_rereset();
        do_reset();
        fire(1'b0, 4'd0, 1'b1, 4'd3, 1'b0, 1'b0, 16'h0);
        check("R11 reg3 cleared", 1'b1, 2'b01);
        fire(1'b0, 4'd0, 1'b1, 4'd15, 1'b0, 1'b0, 16'h0);
        check("R11 stack ptr still set", 1'b0, 2'b00);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_uninit();
        t_written();
        t_stack_ptr();
        t_same_cycle();
        t_branch();
        t_vector();
        t_disabled();
        t_collision();
        t_rereset();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: req=%0b cause=%0d expected run to complete", rst_req, rst_cause);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule